// File: doc/BRIEF.md
# Split-Response Merging Unit

A transaction that was split into pieces, or sent to several targets at once, gets back several 2-bit responses. This block folds those responses into one result for the initiator. A command handshake opens a transaction and states how many sub-responses to expect. The sub-responses then arrive on a valid/ready stream. After the last one is accepted, the block presents one merged response on an output valid/ready stream.

The merge keeps the most severe response seen. From most severe to least severe the order is: decode error, slave error, plain OKAY, exclusive OKAY. A routing failure happens earlier in handling than a target fault, so it ranks highest. A plain OKAY outranks an exclusive OKAY because an exclusive access that succeeded on only some of its parts has not succeeded as a whole.

The block handles one transaction at a time. It accepts no new command and no further sub-response until the merged result has been handed off.

Top module: `rsp_merge_unit`

## Requirements
- R1: After reset, cmd_ready_o is 1, sub_ready_o is 0 and mrg_valid_o is 0.
- R2: The response codes are 2'b00 OKAY, 2'b01 EXOKAY, 2'b10 SLVERR and 2'b11 DECERR. The merged response is the most severe of all accepted sub-responses, ranked DECERR > SLVERR > OKAY > EXOKAY.
- R3: Merging OKAY (2'b00) with EXOKAY (2'b01), in either order, yields OKAY. The merge yields EXOKAY only when every sub-response was EXOKAY.
- R4: With an expected count of 1, the single sub-response is passed to mrg_resp_o unchanged.
- R5: mrg_valid_o stays 0 until exactly the expected number of sub-responses has been accepted. It becomes 1 in the cycle after the final sub-response handshake.
- R6: sub_ready_o is 0 while no transaction is open and while the merged response is pending. A sub-response offered at those times is not accepted and does not change any result.
- R7: While mrg_valid_o is 1 and mrg_ready_i is 0, mrg_valid_o stays 1 and mrg_resp_o holds its value.
- R8: cmd_ready_o is 0 from the command handshake until the merged response handshakes. It returns to 1 in the cycle after that handshake.
- R9: An expected count of 0 is treated as 1.
- R10: Each transaction's accumulator starts from its own first sub-response. No earlier transaction's result carries into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered (opens a transaction) |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_count_i | input | CNT_W | Expected number of sub-responses (0 treated as 1) |
| sub_valid_i | input | 1 | Sub-response offered |
| sub_ready_o | output | 1 | Block can take a sub-response |
| sub_resp_i | input | 2 | Sub-response code |
| mrg_valid_o | output | 1 | Merged response available |
| mrg_ready_i | input | 1 | Downstream takes the merged response |
| mrg_resp_o | output | 2 | Merged response code |

## Verification
A bad accumulator value shows up on mrg_resp_o in the first cycle that mrg_valid_o is high. For example, a leftover result from the previous transaction would turn an all-EXOKAY merge into something more severe. An error in the remaining-count register shows at the ports within one transaction: mrg_valid_o rises one handshake early or late, or never rises. A wrong control state shows at once as a ready or valid that contradicts the open transaction. Examples are sub_ready_o high while a result is pending, or cmd_ready_o high during collection.

// File: rtl/rsp_merge_pkg.sv
package rsp_merge_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2
  } mrg_state_e;

  // severity rank, higher wins
  function automatic logic [1:0] severity(logic [1:0] r);
    case (r)
      RSP_EXOKAY: severity = 2'd0;
      RSP_OKAY:   severity = 2'd1;
      RSP_SLVERR: severity = 2'd2;
      default:    severity = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rsp_merge_pick.sv
module rsp_merge_pick
  import rsp_merge_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic [1:0] new_i,
  output logic [1:0] win_o
);
  always_comb begin
    if (severity(new_i) > severity(acc_i)) win_o = new_i;
    else                                   win_o = acc_i;
  end
endmodule

// File: rtl/rsp_merge_cnt.sv
module rsp_merge_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= (count_i == '0) ? ONE : count_i;
    else if (dec_i)  rem_q <= rem_q - ONE;
  end

  assign last_o = (rem_q == ONE);

  // R5: a decrement never runs the count below zero
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> rem_q != '0);
endmodule

// File: rtl/rsp_merge_unit.sv
module rsp_merge_unit
  import rsp_merge_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [CNT_W-1:0] cmd_count_i,
  input  logic             sub_valid_i,
  output logic             sub_ready_o,
  input  logic [1:0]       sub_resp_i,
  output logic             mrg_valid_o,
  input  logic             mrg_ready_i,
  output logic [1:0]       mrg_resp_o
);
  mrg_state_e state_q, state_d;
  logic [1:0] acc_q, win;
  logic       first_q, last;
  logic       cmd_hs, sub_hs, mrg_hs;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign sub_ready_o = (state_q == ST_COLLECT);
  assign mrg_valid_o = (state_q == ST_EMIT);
  assign mrg_resp_o  = acc_q;

  assign cmd_hs = cmd_valid_i && cmd_ready_o;
  assign sub_hs = sub_valid_i && sub_ready_o;
  assign mrg_hs = mrg_valid_o && mrg_ready_i;

  rsp_merge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd_hs),
    .count_i (cmd_count_i),
    .dec_i   (sub_hs),
    .last_o  (last)
  );

  rsp_merge_pick u_pick (
    .acc_i (acc_q),
    .new_i (sub_resp_i),
    .win_o (win)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (cmd_hs) state_d = ST_COLLECT;
      ST_COLLECT: if (sub_hs && last) state_d = ST_EMIT;
      ST_EMIT:    if (mrg_hs) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= RSP_EXOKAY;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (cmd_hs) first_q <= 1'b1;
      else if (sub_hs) first_q <= 1'b0;
      // seed from the first sub-response of the transaction
      if (sub_hs) acc_q <= first_q ? sub_resp_i : win;
    end
  end

  // R7: pending result holds until taken
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o && !mrg_ready_i |=> mrg_valid_o && $stable(mrg_resp_o));

  // R6: no sub-response taken while result pending
  a_r6_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o |-> !sub_ready_o);

  // R5: result appears only right after a sub-response handshake
  a_r5_emit_after_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mrg_valid_o) |-> $past(sub_valid_i && sub_ready_o));

  // R3: EXOKAY result needs an EXOKAY final input
  a_r3_exokay_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mrg_valid_o) && mrg_resp_o == RSP_EXOKAY |-> $past(sub_resp_i) == RSP_EXOKAY);

  // R8: no new command while a merged result waits
  a_r8_cmd_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o && !mrg_ready_i |=> !cmd_ready_o);
endmodule

// File: tb/rsp_merge_unit_tb.sv
`timescale 1ns/1ps
module rsp_merge_unit_tb;
  localparam int CNT_W = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [CNT_W-1:0] cmd_count = '0;
  logic sub_valid = 0, sub_ready;
  logic [1:0] sub_resp = 2'b00;
  logic mrg_valid, mrg_ready = 0;
  logic [1:0] mrg_resp;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] rs [0:15];

  always #10 clk = ~clk;

  rsp_merge_unit #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_count_i(cmd_count),
    .sub_valid_i(sub_valid), .sub_ready_o(sub_ready), .sub_resp_i(sub_resp),
    .mrg_valid_o(mrg_valid), .mrg_ready_i(mrg_ready), .mrg_resp_o(mrg_resp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // priority scan, independent of any rank table
  function automatic logic [1:0] exp_merge(input int n);
    bit any_dec = 0, any_slv = 0, any_ok = 0;
    for (int i = 0; i < n; i++) begin
      if (rs[i] == 2'b11) any_dec = 1;
      if (rs[i] == 2'b10) any_slv = 1;
      if (rs[i] == 2'b00) any_ok = 1;
    end
    if (any_dec) return 2'b11;
    if (any_slv) return 2'b10;
    if (any_ok)  return 2'b00;
    return 2'b01;
  endfunction

  task automatic txn(input int cnt, input int stall, input string tag);
    int n;
    logic [1:0] exp;
    n = (cnt == 0) ? 1 : cnt;
    exp = exp_merge(n);
    @(negedge clk);
    chk(cmd_ready == 1, "R8 ready when idle", cmd_ready, 1);
    cmd_valid = 1;
    cmd_count = CNT_W'(cnt);
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    chk(cmd_ready == 0, "R8 busy after command", cmd_ready, 0);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(mrg_valid == 0, "R5 no early result", mrg_valid, 0);
      chk(sub_ready == 1, "R6 ready while collecting", sub_ready, 1);
      sub_valid = 1;
      sub_resp = rs[i];
      @(posedge clk); #1 sub_valid = 0;
    end
    @(negedge clk);
    chk(mrg_valid == 1, "R5 result after final sub", mrg_valid, 1);
    chk(mrg_resp == exp, tag, mrg_resp, exp);
    for (int s = 0; s < stall; s++) begin
      sub_valid = 1;
      sub_resp = 2'b11;
      chk(sub_ready == 0, "R6 stalled while pending", sub_ready, 0);
      chk(cmd_ready == 0, "R8 no command while pending", cmd_ready, 0);
      @(negedge clk);
      chk(mrg_valid == 1 && mrg_resp == exp, "R7 result held", mrg_resp, exp);
    end
    sub_valid = 0;
    mrg_ready = 1;
    @(posedge clk); #1 mrg_ready = 0;
    @(negedge clk);
    chk(mrg_valid == 0, "R8 result released", mrg_valid, 0);
    chk(cmd_ready == 1, "R8 ready after handoff", cmd_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    chk(sub_ready == 0, "R1 sub_ready", sub_ready, 0);
    chk(mrg_valid == 0, "R1 mrg_valid", mrg_valid, 0);
    rst_n = 1;

    // R6: sub-response offered while idle is ignored
    @(negedge clk);
    sub_valid = 1; sub_resp = 2'b11;
    repeat (3) begin
      @(negedge clk);
      chk(sub_ready == 0, "R6 idle not ready", sub_ready, 0);
    end
    sub_valid = 0;
    rs[0] = 2'b01; rs[1] = 2'b01;
    txn(2, 0, "R6 idle offer had no effect");

    // R3 both orders, and all EXOKAY
    rs[0] = 2'b00; rs[1] = 2'b01;
    txn(2, 1, "R3 OKAY then EXOKAY");
    rs[0] = 2'b01; rs[1] = 2'b00;
    txn(2, 0, "R3 EXOKAY then OKAY");
    rs[0] = 2'b01; rs[1] = 2'b01; rs[2] = 2'b01;
    txn(3, 0, "R3 all EXOKAY");

    // R2 DECERR over SLVERR
    rs[0] = 2'b10; rs[1] = 2'b11; rs[2] = 2'b00;
    txn(3, 2, "R2 DECERR wins");
    rs[0] = 2'b01; rs[1] = 2'b10; rs[2] = 2'b00;
    txn(3, 0, "R2 SLVERR wins");

    // R4 single pass-through
    for (int v = 0; v < 4; v++) begin
      rs[0] = 2'(v);
      txn(1, 0, "R4 single pass-through");
    end

    // R9 count zero
    rs[0] = 2'b10;
    txn(0, 1, "R9 zero count acts as one");

    // R10 no carry-over after DECERR
    rs[0] = 2'b11;
    txn(1, 0, "R10 setup");
    rs[0] = 2'b01; rs[1] = 2'b01;
    txn(2, 0, "R10 fresh accumulator");

    // full-count boundary
    for (int i = 0; i < 15; i++) rs[i] = 2'b01;
    txn(15, 0, "R5 max count all EXOKAY");

    // random mix
    for (int t = 0; t < 60; t++) begin
      int c;
      c = 1 + int'($urandom % 8);
      for (int i = 0; i < c; i++) rs[i] = 2'($urandom % 4);
      txn(c, int'($urandom % 3), "R2 random merge");
    end

    summary();
  end
endmodule